// File: doc/BRIEF.md
# SPI EEPROM Boot Reader

This block fetches a boot image from one serial EEPROM through an SPI master link and writes it, word by word, into instruction memory. A controller pulses `start_i` together with a word count. The block then selects the EEPROM with its own chip-select output. It sends a read opcode and a two-byte address of zero, and then keeps the serial clock running while data arrives on MISO.

Received bytes are assembled into 32-bit words, with the earliest byte in the least significant lane. Each word goes out on a simple write port at the next instruction-memory address, counting up from a base set by a parameter. When the requested number of words has been stored, the chip select is released and `done_o` is raised. The block does not parse block headers in the boot stream. The word count given at start is the only length information it uses.

Top module: `eeprom_boot_fetch`

## Requirements
- R1: While in reset and after it, `cs_n_o` is high and `sck_o`, `mosi_o`, `imem_we_o` and `done_o` are all low.
- R2: The serial clock follows SPI mode 0. It idles low, has a period of `CLK_DIV` system cycles with equal high and low halves, and its first rising edge comes `CLK_DIV/2` cycles after `cs_n_o` falls. `sck_o` is low whenever `cs_n_o` is high.
- R3: The first 24 bits on `mosi_o` go out MSB first: the read opcode 0x03 followed by address bytes 0x00 and 0x00. After these bits `mosi_o` stays low until the chip select is released.
- R4: MISO is sampled on each rising SCK edge, MSB first. The k-th received byte (k from 0) goes to bits [8*(k mod 4)+7 : 8*(k mod 4)] of word k/4. Word j is written to address `BASE_ADDR + j`, and the words are written in increasing order.
- R5: For a count of N, `imem_we_o` pulses exactly N times. Each pulse lasts one cycle and comes in the cycle after the last bit of that word's fourth byte is sampled.
- R6: `cs_n_o` falls once per transfer and stays low throughout it. It rises exactly `CLK_DIV` cycles after the last rising SCK edge. `done_o` rises in that same cycle and stays high until the next accepted start.
- R7: A `start_i` pulse during a transfer is ignored. The number of words, their contents and the chip-select timing are the same as if the pulse had not occurred.
- R8: The word count is captured only when a start is accepted, so later changes to it have no effect. A count of zero sends only the opcode and address, writes nothing and then finishes as in R6.
- R9: A transfer of N words produces exactly 24 + 32*N rising SCK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only when idle |
| word_count_i | input | WCNT_W | Number of 32-bit words to load |
| sck_o | output | 1 | Serial clock to the EEPROM |
| mosi_o | output | 1 | Serial data to the EEPROM |
| miso_i | input | 1 | Serial data from the EEPROM |
| cs_n_o | output | 1 | Active-low select of the single EEPROM |
| imem_addr_o | output | ADDR_W | Instruction-memory word address |
| imem_data_o | output | 32 | Instruction-memory write data |
| imem_we_o | output | 1 | Write strobe, one cycle per word |
| done_o | output | 1 | Load finished; held until next start |

## Verification
The assertions rely on a few conditions at the inputs. `CLK_DIV` must be even and at least 2, so that writes fall strictly inside the chip-select window. MISO must change only on a falling SCK edge and be stable at the next rising edge. Start is a single-cycle request. The bench meets these conditions with an EEPROM model that drives MISO only from the falling SCK edge. It pulses start for one cycle at the falling system-clock edge. Its start pulses during a transfer always land well before the final byte, and it picks word counts small enough that the image fits the model.

// File: rtl/boot_rd_pkg.sv
package boot_rd_pkg;

    localparam logic [7:0] READ_OPCODE = 8'h03;
    localparam int         HDR_BYTES   = 3;

    typedef enum logic [1:0] {
        BR_IDLE,
        BR_HDR,
        BR_DATA,
        BR_TAIL
    } br_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic stop;
    } sck_evt_t;

    typedef logic [3:0][7:0] word_bytes_t;

    // Header byte sent at a given position: opcode, then a zero address.
    function automatic logic [7:0] hdr_byte(input logic [1:0] idx);
        return (idx == 2'd0) ? READ_OPCODE : 8'h00;
    endfunction

endpackage

// File: rtl/br_sck_gen.sv
module br_sck_gen
    import boot_rd_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_i,
    input  logic     hold_low_i,
    output logic     sck_o,
    output sck_evt_t evt_o
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;
    logic          sck_q;
    logic          tick;

    assign tick       = en_i && (cnt_q == CW'(HALF - 1));
    assign evt_o.rise = tick && !sck_q && !hold_low_i;
    assign evt_o.fall = tick && sck_q;
    assign evt_o.stop = tick && !sck_q && hold_low_i;
    assign sck_o      = sck_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
            if (evt_o.rise)      sck_q <= 1'b1;
            else if (evt_o.fall) sck_q <= 1'b0;
        end
    end

    AST_SCK_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (en_i && hold_low_i && !sck_q) |=> !sck_q); // R6

endmodule

// File: rtl/br_shifter.sv
module br_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] load_byte_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic [7:0] next_byte_i,
    input  logic       miso_i,
    output logic       mosi_o,
    output logic       byte_done_o,
    output logic [7:0] rx_byte_o
);
    logic [7:0] tx_q;
    logic [6:0] rx_q;
    logic [2:0] bit_cnt_q;

    assign mosi_o      = tx_q[7];
    assign byte_done_o = rise_i && (bit_cnt_q == 3'd7);
    assign rx_byte_o   = {rx_q, miso_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q      <= '0;
            rx_q      <= '0;
            bit_cnt_q <= '0;
        end else if (load_i) begin
            tx_q      <= load_byte_i;
            bit_cnt_q <= '0;
        end else begin
            if (rise_i) begin
                rx_q      <= rx_byte_o[6:0];
                bit_cnt_q <= bit_cnt_q + 3'd1;
            end
            if (fall_i) begin
                tx_q <= (bit_cnt_q == 3'd0) ? next_byte_i : {tx_q[6:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/br_packer.sv
module br_packer
    import boot_rd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BASE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              stb_i,
    input  logic [7:0]        byte_i,
    output logic              last_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [31:0]       data_o
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    logic [1:0]        sel_q;
    word_bytes_t       acc_q;
    word_bytes_t       word_next;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       data_q;
    logic              we_q;

    always_comb begin
        word_next        = acc_q;
        word_next[sel_q] = byte_i;
    end

    assign last_o = (sel_q == 2'd3);
    assign we_o   = we_q;
    assign addr_o = addr_q;
    assign data_o = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            acc_q  <= '0;
            ptr_q  <= BASE;
            addr_q <= BASE;
            data_q <= '0;
            we_q   <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (clear_i) begin
                sel_q <= '0;
                ptr_q <= BASE;
            end else if (stb_i) begin
                sel_q <= sel_q + 2'd1;
                acc_q <= word_next;
                if (last_o) begin
                    data_q <= word_next;
                    addr_q <= ptr_q;
                    ptr_q  <= ptr_q + 1'b1;
                    we_q   <= 1'b1;
                end
            end
        end
    end

    AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        we_q |=> !we_q); // R5

endmodule

// File: rtl/eeprom_boot_fetch.sv
module eeprom_boot_fetch
    import boot_rd_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int ADDR_W    = 12,
    parameter int WCNT_W    = 10,
    parameter int BASE_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WCNT_W-1:0] word_count_i,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic              cs_n_o,
    output logic [ADDR_W-1:0] imem_addr_o,
    output logic [31:0]       imem_data_o,
    output logic              imem_we_o,
    output logic              done_o
);
    localparam logic [1:0] LAST_HDR = 2'(HDR_BYTES - 1);

    br_state_e         state_q;
    logic              cs_n_q;
    logic              done_q;
    logic [1:0]        hdr_idx_q;
    logic [WCNT_W-1:0] words_left_q;

    sck_evt_t   evt;
    logic       start_ok;
    logic       byte_done;
    logic [7:0] rx_byte;
    logic [7:0] next_byte;
    logic       pk_last;
    logic       data_stb;

    assign start_ok  = start_i && (state_q == BR_IDLE);
    assign next_byte = (state_q == BR_HDR) ? hdr_byte(hdr_idx_q) : 8'h00;
    assign data_stb  = byte_done && (state_q == BR_DATA);
    assign cs_n_o    = cs_n_q;
    assign done_o    = done_q;

    br_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
        .clk        (clk),
        .rst        (rst),
        .en_i       (state_q != BR_IDLE),
        .hold_low_i (state_q == BR_TAIL),
        .sck_o      (sck_o),
        .evt_o      (evt)
    );

    br_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .load_i      (start_ok),
        .load_byte_i (hdr_byte(2'd0)),
        .rise_i      (evt.rise),
        .fall_i      (evt.fall),
        .next_byte_i (next_byte),
        .miso_i      (miso_i),
        .mosi_o      (mosi_o),
        .byte_done_o (byte_done),
        .rx_byte_o   (rx_byte)
    );

    br_packer #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_ok),
        .stb_i   (data_stb),
        .byte_i  (rx_byte),
        .last_o  (pk_last),
        .we_o    (imem_we_o),
        .addr_o  (imem_addr_o),
        .data_o  (imem_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= BR_IDLE;
            cs_n_q       <= 1'b1;
            done_q       <= 1'b0;
            hdr_idx_q    <= '0;
            words_left_q <= '0;
        end else begin
            case (state_q)
                BR_IDLE: if (start_i) begin
                    state_q      <= BR_HDR;
                    cs_n_q       <= 1'b0;
                    done_q       <= 1'b0;
                    hdr_idx_q    <= '0;
                    words_left_q <= word_count_i;
                end
                BR_HDR: if (byte_done) begin
                    hdr_idx_q <= hdr_idx_q + 2'd1;
                    if (hdr_idx_q == LAST_HDR)
                        state_q <= (words_left_q == '0) ? BR_TAIL : BR_DATA;
                end
                BR_DATA: if (byte_done && pk_last) begin
                    words_left_q <= words_left_q - 1'b1;
                    if (words_left_q == WCNT_W'(1)) state_q <= BR_TAIL;
                end
                BR_TAIL: if (evt.stop) begin
                    state_q <= BR_IDLE;
                    cs_n_q  <= 1'b1;
                    done_q  <= 1'b1;
                end
                default: state_q <= BR_IDLE;
            endcase
        end
    end

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n_q |-> !sck_o); // R2
    AST_MOSI_QUIET_DATA: assert property (@(posedge clk) disable iff (rst)
        (state_q == BR_DATA) |-> !mosi_o); // R3
    AST_WE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (rst)
        imem_we_o |-> !cs_n_q); // R6
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
        (done_q && !start_i) |=> done_q); // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q != BR_IDLE && start_i) |=> (state_q != BR_HDR || $past(state_q) == BR_HDR)); // R7

endmodule

// File: tb/eeprom_boot_fetch_bench.sv
module eeprom_boot_fetch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int AW         = 12;
    localparam int CW         = 10;
    localparam int BASE       = 0;
    localparam int LIMIT      = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [CW-1:0] word_count_i = '0;
    logic          sck_o, mosi_o, cs_n_o, imem_we_o, done_o;
    logic          miso_i = 1'b0;
    logic [AW-1:0] imem_addr_o;
    logic [31:0]   imem_data_o;

    eeprom_boot_fetch #(.CLK_DIV(DIV), .ADDR_W(AW), .WCNT_W(CW), .BASE_ADDR(BASE))
    u_eeprom_boot_fetch (
        .clk(clk), .rst(rst), .start_i(start_i), .word_count_i(word_count_i),
        .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o),
        .imem_addr_o(imem_addr_o), .imem_data_o(imem_data_o),
        .imem_we_o(imem_we_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    longint cyc  = 0;

    // EEPROM model state
    logic [7:0]  mem [64];
    int          rcnt, mosi_bad, per_err, cs_falls;
    logic [23:0] cmd;
    longint      last_rise, first_rise, cs_fall_cyc, cs_rise_cyc;

    // write monitor
    logic [AW-1:0] wr_addr [16];
    logic [31:0]   wr_data [16];
    int            nwr, dbl;
    logic          we_prev = 1'b0;

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge cs_n_o) begin
        rcnt = 0; cmd = '0; mosi_bad = 0; per_err = 0;
        cs_falls = cs_falls + 1;
        cs_fall_cyc = cyc;
        miso_i = 1'b0;
    end

    always @(posedge cs_n_o) cs_rise_cyc = cyc;

    always @(posedge sck_o) if (!cs_n_o) begin
        if (rcnt < 24) cmd = {cmd[22:0], mosi_o};
        else if (mosi_o) mosi_bad = mosi_bad + 1;
        if (rcnt == 0) first_rise = cyc;
        else if (cyc - last_rise != DIV) per_err = per_err + 1;
        last_rise = cyc;
        rcnt = rcnt + 1;
    end

    always @(negedge sck_o) if (!cs_n_o && rcnt >= 24) begin
        int idx;
        idx = rcnt - 24;
        miso_i = mem[(idx / 8) % 64][7 - (idx % 8)];
    end

    always @(posedge clk) if (!rst) begin
        if (imem_we_o) begin
            if (nwr < 16) begin
                wr_addr[nwr] = imem_addr_o;
                wr_data[nwr] = imem_data_o;
            end
            nwr = nwr + 1;
            if (we_prev) dbl = dbl + 1;
        end
        we_prev = imem_we_o;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int k);
        return {mem[4*k+3], mem[4*k+2], mem[4*k+1], mem[4*k]};
    endfunction

    task automatic run_xfer(input int n, input int pat, input bit poke);
        int wd;
        for (int i = 0; i < 64; i++)
            mem[i] = (pat == 1) ? 8'hFF : (pat == 2) ? 8'(i + 1) : 8'($urandom);
        nwr = 0; dbl = 0; cs_falls = 0;
        @(negedge clk);
        word_count_i = CW'(n);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        word_count_i = CW'($urandom);           // R8: must not matter
        chk(!cs_n_o && !done_o, "R6", "select/done after start", {cs_n_o, done_o}, 2'b00);
        if (poke) begin
            repeat (20 + $urandom % 50) @(negedge clk);
            word_count_i = CW'(n + 3);
            start_i = 1'b1;                      // R7: ignored while busy
            @(negedge clk);
            start_i = 1'b0;
        end
        wd = 0;
        while (!done_o && wd < LIMIT) begin
            @(negedge clk);
            wd++;
        end
        chk(wd < LIMIT, "R6", "watchdog, done never rose", wd, LIMIT);
        chk(cmd == 24'h030000, "R3", "opcode and address bits", cmd, 24'h030000);
        chk(mosi_bad == 0, "R3", "mosi high after header", mosi_bad, 0);
        chk(per_err == 0, "R2", "sck period errors", per_err, 0);
        chk(first_rise - cs_fall_cyc == DIV/2, "R2", "first rise delay",
            first_rise - cs_fall_cyc, DIV/2);
        chk(rcnt == 24 + 32*n, "R9", "rising sck edges", rcnt, 24 + 32*n);
        chk(nwr == n, "R5", "write strobes", nwr, n);
        chk(dbl == 0, "R5", "strobe wider than one cycle", dbl, 0);
        chk(cs_falls == 1, "R7", "chip select falls", cs_falls, 1);
        chk(cs_rise_cyc - last_rise == DIV, "R6", "release after last rise",
            cs_rise_cyc - last_rise, DIV);
        for (int k = 0; k < n && k < 16; k++) begin
            chk(wr_addr[k] == AW'(BASE + k), "R4", "write address", wr_addr[k], BASE + k);
            chk(wr_data[k] == exp_word(k), "R4", "write data", wr_data[k], exp_word(k));
        end
        repeat (5) @(negedge clk);
        chk(done_o && cs_n_o && !sck_o, "R6", "done held, idle outputs",
            {done_o, cs_n_o, sck_o}, 3'b110);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        repeat (4) @(negedge clk);
        chk(cs_n_o && !sck_o && !mosi_o && !imem_we_o && !done_o, "R1", "outputs in reset",
            {cs_n_o, sck_o, mosi_o, imem_we_o, done_o}, 5'b10000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n_o && !sck_o && !mosi_o && !imem_we_o && !done_o, "R1", "outputs after reset",
            {cs_n_o, sck_o, mosi_o, imem_we_o, done_o}, 5'b10000);

        run_xfer(0, 0, 1'b0);                    // R8 zero count
        run_xfer(1, 1, 1'b0);                    // R4 all-ones image
        run_xfer(2, 2, 1'b1);                    // R7 start during transfer
        run_xfer(8, 2, 1'b0);                    // R4 byte order, longest
        for (int t = 0; t < 6; t++)
            run_xfer(1 + int'($urandom % 8), 0, 1'($urandom % 2));

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule